// File: doc/BRIEF.md
# Serial Step-Attenuator Control Register

This block is the digital front end of a six-bit step attenuator. A host writes a control word over three wires: a serial clock, a data line and a latch enable. All three are brought into a faster system clock domain through a synchronizer. Rising edges of the serial clock shift the data into a shift register, most significant bit first. A latch stage then passes the shift register contents on to the attenuator.

The latch is transparent while latch enable is high. When latch enable falls, the latch holds its current value. Serial clock edges are ignored while latch enable is high, so loading a word takes two steps: shift it in with latch enable low, then pulse latch enable. The control bits are active-low. The block also gives the attenuation in half-dB steps, which is the bitwise inverse of the latched word.

A counter on the system clock measures the time between rising edges of latch enable. If two edges arrive closer together than a configurable minimum, a sticky violation flag is set.

Top module: `step_atten_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, the control word is 6'b000000 (maximum attenuation), the attenuation output is 63 and the violation flag is 0.
- R2: Each rising edge of the serial clock while latch enable is low shifts one data bit into the shift register, most significant bit first. After six edges and a latch pulse, the control word equals the six bits in the order sent.
- R3: Serial clock edges that occur while latch enable is high do not shift. A later latch pulse shows the shift register contents from before those edges.
- R4: While latch enable is high, the control word follows the shift register contents. After latch enable falls, the value that was present is held.
- R5: Shifting a new word while latch enable is low does not change the control word until the next latch pulse.
- R6: The attenuation output, in 0.5 dB units, is the sum of 2^k over every bit k of the control word that is 0. This gives 0 for the all-ones word and 63 for the all-zeros word.
- R7: The violation flag is set when two rising edges of latch enable are fewer than MIN_GAP system clocks apart. It stays clear at exactly MIN_GAP clocks apart.
- R8: Once set, the violation flag stays set through later latch activity until reset.
- R9: The first rising edge of latch enable after reset never sets the violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le | input | 1 | Latch enable (asynchronous) |
| ctrl_word | output | 6 | Latched active-low control word to the attenuator |
| atten_hdb | output | 6 | Attenuation in 0.5 dB units |
| le_gap_viol | output | 1 | Sticky flag for latch-enable pulses spaced too closely |

## Verification
The bench builds the block with MIN_GAP set to 8 system clocks instead of the default 63. This makes both sides of the spacing boundary cheap to reach: a gap of 7 clocks must set the flag and a gap of 8 must not. The synchronizer depth stays at 2, and the serial clock is driven slowly enough that every edge is detected. The vector table covers each single-bit weight, the all-ones word and the all-zeros word, alongside mixed patterns.

// File: rtl/sac_pkg.sv
// Package: shared width and synchronizer bundle for the step-attenuator control.
// Assumes a 6-bit control word unless a top parameter overrides it.
package sac_pkg;
    localparam int unsigned SAC_WORD_W = 6;
    localparam int unsigned SAC_SER_W  = 3;

    typedef struct packed {
        logic le;
        logic data;
        logic sclk;
    } sac_ser_t;
endpackage

// File: rtl/sac_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes inputs stay stable for several system clocks; resets to zero.
module sac_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    if (s == 0) stage_q[s] <= async_in;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sac_shift_latch.sv
// Module: serial shift register and level-sensitive control latch.
// Shifts MSB first on detected serial clock rises while latch enable is low;
// copies the shift register into the held word while latch enable is high.
module sac_shift_latch #(
    parameter int unsigned WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              data_s,
    input  logic              le_s,
    output logic              sclk_rise,
    output logic [WORD_W-1:0] shreg,
    output logic [WORD_W-1:0] word
);
    logic sclk_q;

    // Remember the previous synchronized serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_q;

    // Shift one bit in on a serial clock rise, gated off while latch enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                 shreg <= '0;
        else if (sclk_rise && !le_s) shreg <= {shreg[WORD_W-2:0], data_s};
    end

    // Transparent while latch enable is high, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= '0;
        else if (le_s) word <= shreg;
    end
endmodule

// File: rtl/sac_le_spacing.sv
// Module: measures system clocks between latch-enable rises and sets a
// sticky flag when a gap is shorter than MIN_GAP. Assumes MIN_GAP >= 2.
module sac_le_spacing #(
    parameter int unsigned MIN_GAP = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic le_s,
    output logic le_rise,
    output logic viol
);
    localparam int unsigned CNT_W   = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_GAP - 1);

    logic             le_q;
    logic             armed;
    logic [CNT_W-1:0] gap_cnt;

    // Remember the previous synchronized latch enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= 1'b0;
        else        le_q <= le_s;
    end

    assign le_rise = le_s & ~le_q;

    // Count clocks since the last rise, saturating; check and restart on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            armed   <= 1'b0;
            viol    <= 1'b0;
        end else if (le_rise) begin
            if (armed && gap_cnt < CNT_MAX) viol <= 1'b1;
            gap_cnt <= '0;
            armed   <= 1'b1;
        end else if (gap_cnt != CNT_MAX) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/step_atten_ctrl.sv
// Module: top of the serial step-attenuator control register.
// Synchronizes the three serial inputs, shifts and latches the active-low
// word, decodes it into half-dB units and watches latch-enable spacing.
module step_atten_ctrl #(
    parameter int unsigned WORD_W      = sac_pkg::SAC_WORD_W,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_GAP     = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] atten_hdb,
    output logic              le_gap_viol
);
    import sac_pkg::*;

    sac_ser_t          raw_in;
    sac_ser_t          syn;
    logic              le_s;
    logic              sclk_rise;
    logic              le_rise;
    logic [WORD_W-1:0] shreg;

    assign raw_in = '{le: ser_le, data: ser_data, sclk: ser_clk};

    sac_sync #(.WIDTH(SAC_SER_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (syn)
    );

    assign le_s = syn.le;

    sac_shift_latch #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (syn.sclk),
        .data_s    (syn.data),
        .le_s      (le_s),
        .sclk_rise (sclk_rise),
        .shreg     (shreg),
        .word      (ctrl_word)
    );

    sac_le_spacing #(.MIN_GAP(MIN_GAP)) u_space (
        .clk     (clk),
        .rst_n   (rst_n),
        .le_s    (le_s),
        .le_rise (le_rise),
        .viol    (le_gap_viol)
    );

    // Active-low bits: each zero adds its binary weight in half-dB steps.
    assign atten_hdb = ~ctrl_word;
endmodule

// File: rtl/step_atten_ctrl_chk.sv
// Module: property checker bound to the control register top.
// Assumes it sees the synchronized latch enable and the internal shift state.
module step_atten_ctrl_chk #(
    parameter int unsigned WORD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              le_s,
    input logic              sclk_rise,
    input logic              le_rise,
    input logic [WORD_W-1:0] shreg,
    input logic [WORD_W-1:0] ctrl_word,
    input logic              le_gap_viol
);
    // R2
    msb_first_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !le_s) |=> shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0]));
    // R3
    gated_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_s |=> $stable(shreg));
    // R5
    held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctrl_word)) |-> $past(le_s));
    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_gap_viol |=> le_gap_viol);
    // R7
    flag_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le_gap_viol) |-> $past(le_rise));
endmodule

bind step_atten_ctrl step_atten_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .le_s        (le_s),
    .sclk_rise   (sclk_rise),
    .le_rise     (le_rise),
    .shreg       (shreg),
    .ctrl_word   (ctrl_word),
    .le_gap_viol (le_gap_viol)
);

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
    localparam int W   = 6;
    localparam int GAP = 8;
    localparam int NV  = 10;
    localparam logic [W-1:0] VEC [NV] = '{6'b111111, 6'b111110, 6'b111101,
        6'b111011, 6'b110111, 6'b101111, 6'b011111, 6'b000000, 6'b101010, 6'b010011};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [W-1:0] ctrl_word, atten_hdb;
    logic le_gap_viol;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    step_atten_ctrl #(.WORD_W(W), .SYNC_STAGES(2), .MIN_GAP(GAP)) u_step_atten_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .ctrl_word(ctrl_word), .atten_hdb(atten_hdb),
        .le_gap_viol(le_gap_viol));

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int weight_sum(input logic [W-1:0] w);
        int s = 0;
        for (int k = 0; k < W; k++) if (!w[k]) s += (1 << k);
        return s;
    endfunction

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W-1; i >= 0; i--) begin
            ser_data = w[i]; wait_n(3);
            ser_clk = 1'b1;  wait_n(3);
            ser_clk = 1'b0;  wait_n(3);
        end
    endtask

    task automatic le_pulse();
        ser_le = 1'b1; wait_n(4);
        ser_le = 1'b0; wait_n(GAP + 6);
    endtask

    task automatic gap_pair(input int g);
        ser_le = 1'b1; wait_n(2);
        ser_le = 1'b0; wait_n(g - 2);
        ser_le = 1'b1; wait_n(2);
        ser_le = 1'b0; wait_n(GAP + 6);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(4);
        // R1 reset state
        check("R1 word", int'(ctrl_word), 0);
        check("R1 atten", int'(atten_hdb), 63);
        check("R1 flag", int'(le_gap_viol), 0);
        rst_n = 1'b1; wait_n(3);

        // R9: first latch pulse after reset never flags
        le_pulse();
        check("R9 flag", int'(le_gap_viol), 0);

        // R2, R6 vector table
        for (int v = 0; v < NV; v++) begin
            shift_word(VEC[v]);
            le_pulse();
            check("R2 word", int'(ctrl_word), int'(VEC[v]));
            check("R6 atten", int'(atten_hdb), weight_sum(VEC[v]));
        end

        // R5: shifting with latch low leaves the output alone
        shift_word(6'b100001);
        le_pulse();
        shift_word(6'b011110);
        check("R5 held", int'(ctrl_word), 6'b100001);
        le_pulse();
        check("R5 loaded", int'(ctrl_word), 6'b011110);

        // R3: clock edges while latch enable is high are ignored
        ser_le = 1'b1; wait_n(4);
        for (int i = 0; i < W; i++) begin
            ser_data = i[0]; wait_n(3);
            ser_clk = 1'b1;  wait_n(3);
            ser_clk = 1'b0;  wait_n(3);
        end
        ser_le = 1'b0; wait_n(GAP + 6);
        le_pulse();
        check("R3 word", int'(ctrl_word), 6'b011110);

        // R4: transparent while high, then held
        shift_word(6'b110010);
        ser_le = 1'b1; wait_n(5);
        check("R4 transparent", int'(ctrl_word), 6'b110010);
        ser_le = 1'b0; wait_n(GAP + 6);
        shift_word(6'b001101);
        check("R4 hold", int'(ctrl_word), 6'b110010);

        // R7 boundary: exactly MIN_GAP apart is fine, one less flags
        check("R7 pre", int'(le_gap_viol), 0);
        gap_pair(GAP);
        check("R7 at gap", int'(le_gap_viol), 0);
        gap_pair(GAP - 1);
        check("R7 short gap", int'(le_gap_viol), 1);

        // R8 sticky through later well-spaced activity
        le_pulse(); le_pulse();
        check("R8 sticky", int'(le_gap_viol), 1);

        // R1 reset clears everything
        rst_n = 1'b0; wait_n(4);
        check("R1 flag cleared", int'(le_gap_viol), 0);
        check("R1 word again", int'(ctrl_word), 0);
        rst_n = 1'b1; wait_n(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule